// File: doc/BRIEF.md
# Two-Share Masked Chunk Multiplier

This block multiplies secrets that never appear in the clear. Each secret operand arrives as two arithmetic shares. The shares sum to the secret modulo 2^K, where K is the chunk width. An operand word is split into several K-bit lanes, and every lane is an independent chunk multiply. Each lane needs only a K-by-K partial product, so it fits a small hardware multiplier with K up to 17. Lanes whose results must later be combined into a wider product hand their share sums, including the bits dropped at the top of each lane, to a separate carry-recovery stage.

In every lane the four cross products of the shares are formed. Each one is refreshed with a fresh random value, and the refreshed terms are registered before any further combination. The first output share collects the terms that involve the first share of A. The second output share collects the terms that involve the second share of A. The randomness input is a fixed 32 bits per accepted beat, whatever the operand width. The lane count follows from it as 32 / (2K).

Both data sides use valid/ready handshakes. A beat moves across an edge when valid and ready are both high at that rising clock edge. A source must hold its data stable while valid is high and ready is low. Downstream back-pressure stalls the two-stage pipeline. While a result is waiting it stays frozen on the outputs. Once both stages are full, the input side drops ready.

Top module: `mcm_share_mult`

## Requirements
- R1: During reset and in the first cycle after it, m_valid is 0 and s_ready is 1. A reset drops every beat still in flight.
- R2: In every lane, (m_c0 + m_c1) mod 2^K equals (a0 + a1)·(b0 + b1) mod 2^K. This holds whatever randomness is supplied.
- R3: Lane l takes its operand bits from [l·K +: K] of each share bus. It takes its two random values from s_rnd: r0 from bits [2l·K +: K] and r1 from bits [(2l+1)·K +: K].
- R4: Define, all mod 2^K, t00 = a0·b0 + r0, t01 = a0·b1 + r1, t10 = a1·b0 − r0 and t11 = a1·b1 − r1. Then m_c0 = (t00 + t01) mod 2^K and m_c1 = (t10 + t11) mod 2^K.
- R5: m_cy0[l] is the carry out of the K-bit sum t00 + t01. m_cy1[l] is the carry out of the K-bit sum t10 + t11.
- R6: A beat accepted on one edge, with the pipeline empty and m_ready high, shows on m_valid after the second edge. Beats can be accepted on back-to-back cycles.
- R7: While m_valid is high and m_ready is low, m_valid and all result outputs stay unchanged. With the output stalled and both stages full, s_ready is 0.
- R8: Results leave in the order the beats were accepted. No beat is lost or duplicated under any pattern of s_valid and m_ready.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input beat present |
| s_ready | output | 1 | Block can take an input beat |
| s_a0 | input | LANES·K (16) | Operand A, share 0, all lanes |
| s_a1 | input | LANES·K (16) | Operand A, share 1, all lanes |
| s_b0 | input | LANES·K (16) | Operand B, share 0, all lanes |
| s_b1 | input | LANES·K (16) | Operand B, share 1, all lanes |
| s_rnd | input | RND_W (32) | Fresh refresh randomness for the beat |
| m_valid | output | 1 | Result beat present |
| m_ready | input | 1 | Downstream takes the result |
| m_c0 | output | LANES·K (16) | Product share 0, all lanes |
| m_c1 | output | LANES·K (16) | Product share 1, all lanes |
| m_cy0 | output | LANES (2) | Per-lane carry dropped from share-0 sum |
| m_cy1 | output | LANES (2) | Per-lane carry dropped from share-1 sum |

## Verification
Every result comes out two edges after its input beat is accepted, provided downstream is ready. Stalls hold that result in place for as long as m_ready stays low. The bench applies inputs at the falling edge. Just before the next rising edge it records an input transfer whenever s_valid and s_ready are both high, and an output transfer whenever m_valid and m_ready are both high. Each recorded output transfer is compared against the oldest beat still waiting in a queue, so checking does not depend on a fixed delay. The fixed two-edge delay and the frozen outputs during a stall are checked separately, at falling edges counted from the accepting edge.

// File: rtl/mcm_pkg.sv
package mcm_pkg;

  // Widest operand one partial-product multiplier takes on its narrow side.
  localparam int MCM_MUL_NARROW_MAX = 17;

  // Each lane consumes two K-bit random values per beat.
  function automatic int mcm_lanes(input int rnd_w, input int chunk_w);
    return rnd_w / (2 * chunk_w);
  endfunction

endpackage

// File: rtl/mcm_pipe_ctl.sv
module mcm_pipe_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  output logic s_ready,
  input  logic m_ready,
  output logic m_valid,
  output logic ld_x,
  output logic ld_s
);

  logic vx_q, vs_q;
  logic adv_s, adv_x;

  // Output stage may change when it is empty or being drained.
  assign adv_s   = !vs_q || m_ready;
  // Cross-product stage may change when empty or when it can move on.
  assign adv_x   = !vx_q || adv_s;
  assign s_ready = adv_x;
  assign ld_x    = adv_x && s_valid;
  assign ld_s    = adv_s && vx_q;
  assign m_valid = vs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vx_q <= 1'b0;
      vs_q <= 1'b0;
    end else begin
      if (adv_x) vx_q <= s_valid;
      if (adv_s) vs_q <= vx_q;
    end
  end

  // R7: a stalled result does not vanish
  a_r7_valid_held: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> m_valid);

  // R6: an accepted beat occupies the first stage on the next cycle
  a_r6_accept_fills: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> vx_q);

  // R6: a full first stage with room downstream yields a result next cycle
  a_r6_moves_on: assert property (@(posedge clk) disable iff (!rst_n)
    (vx_q && (!m_valid || m_ready)) |=> m_valid);

endmodule

// File: rtl/mcm_xprod_lane.sv
module mcm_xprod_lane #(
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [K-1:0] a0,
  input  logic [K-1:0] a1,
  input  logic [K-1:0] b0,
  input  logic [K-1:0] b1,
  input  logic [K-1:0] r0,
  input  logic [K-1:0] r1,
  output logic [K-1:0] t00,
  output logic [K-1:0] t01,
  output logic [K-1:0] t10,
  output logic [K-1:0] t11
);

  logic [K-1:0] p00, p01, p10, p11;
  logic [K-1:0] n00, n01, n10, n11;

  // Only the low K bits of each K-by-K product matter modulo 2^K.
  assign p00 = a0 * b0;
  assign p01 = a0 * b1;
  assign p10 = a1 * b0;
  assign p11 = a1 * b1;

  // Refresh: the masks added on the share-0 side are removed on share-1.
  assign n00 = p00 + r0;
  assign n01 = p01 + r1;
  assign n10 = p10 - r0;
  assign n11 = p11 - r1;

  // Registered barrier so no glitch path joins terms from both shares.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      t00 <= '0;
      t01 <= '0;
      t10 <= '0;
      t11 <= '0;
    end else if (ld) begin
      t00 <= n00;
      t01 <= n01;
      t10 <= n10;
      t11 <= n11;
    end
  end

  logic [K-1:0] secret_prod, term_total;
  assign secret_prod = (a0 + a1) * (b0 + b1);
  assign term_total  = t00 + t01 + t10 + t11;

  // R2: the four stored terms recombine to the unmasked lane product
  a_r2_terms_recombine: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (term_total == $past(secret_prod)));

  // R7: stored terms move only on a load
  a_r7_terms_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ld |=> ($stable(t00) && $stable(t01) && $stable(t10) && $stable(t11)));

endmodule

// File: rtl/mcm_sum_lane.sv
module mcm_sum_lane #(
  parameter int K = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ld,
  input  logic [K-1:0] t00,
  input  logic [K-1:0] t01,
  input  logic [K-1:0] t10,
  input  logic [K-1:0] t11,
  output logic [K-1:0] c0,
  output logic [K-1:0] c1,
  output logic         cy0,
  output logic         cy1
);

  logic [K:0] w0, w1;

  // One extra bit keeps the carry that reduction mod 2^K would drop.
  assign w0 = {1'b0, t00} + {1'b0, t01};
  assign w1 = {1'b0, t10} + {1'b0, t11};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c0  <= '0;
      c1  <= '0;
      cy0 <= 1'b0;
      cy1 <= 1'b0;
    end else if (ld) begin
      c0  <= w0[K-1:0];
      c1  <= w1[K-1:0];
      cy0 <= w0[K];
      cy1 <= w1[K];
    end
  end

  logic [K-1:0] in_total, out_total;
  assign in_total  = t00 + t01 + t10 + t11;
  assign out_total = c0 + c1;

  // R2: summing into two shares keeps the recombined value
  a_r2_shares_keep_value: assert property (@(posedge clk) disable iff (!rst_n)
    ld |=> (out_total == $past(in_total)));

endmodule

// File: rtl/mcm_share_mult.sv
module mcm_share_mult #(
  parameter int CHUNK_W = 8,
  parameter int RND_W   = 32,
  localparam int LANES  = mcm_pkg::mcm_lanes(RND_W, CHUNK_W),
  localparam int OPW    = LANES * CHUNK_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [OPW-1:0]   s_a0,
  input  logic [OPW-1:0]   s_a1,
  input  logic [OPW-1:0]   s_b0,
  input  logic [OPW-1:0]   s_b1,
  input  logic [RND_W-1:0] s_rnd,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [OPW-1:0]   m_c0,
  output logic [OPW-1:0]   m_c1,
  output logic [LANES-1:0] m_cy0,
  output logic [LANES-1:0] m_cy1
);

  logic ld_x, ld_s;

  mcm_pipe_ctl i_ctl (
    .clk     (clk),
    .rst_n   (rst_n),
    .s_valid (s_valid),
    .s_ready (s_ready),
    .m_ready (m_ready),
    .m_valid (m_valid),
    .ld_x    (ld_x),
    .ld_s    (ld_s)
  );

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [CHUNK_W-1:0] t00, t01, t10, t11;

    mcm_xprod_lane #(.K(CHUNK_W)) i_xprod (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ld_x),
      .a0    (s_a0[l*CHUNK_W +: CHUNK_W]),
      .a1    (s_a1[l*CHUNK_W +: CHUNK_W]),
      .b0    (s_b0[l*CHUNK_W +: CHUNK_W]),
      .b1    (s_b1[l*CHUNK_W +: CHUNK_W]),
      .r0    (s_rnd[(2*l)*CHUNK_W +: CHUNK_W]),
      .r1    (s_rnd[(2*l+1)*CHUNK_W +: CHUNK_W]),
      .t00   (t00),
      .t01   (t01),
      .t10   (t10),
      .t11   (t11)
    );

    mcm_sum_lane #(.K(CHUNK_W)) i_sum (
      .clk   (clk),
      .rst_n (rst_n),
      .ld    (ld_s),
      .t00   (t00),
      .t01   (t01),
      .t10   (t10),
      .t11   (t11),
      .c0    (m_c0[l*CHUNK_W +: CHUNK_W]),
      .c1    (m_c1[l*CHUNK_W +: CHUNK_W]),
      .cy0   (m_cy0[l]),
      .cy1   (m_cy1[l])
    );
  end

  // R7: a stalled result is frozen on every output
  a_r7_result_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> ($stable(m_c0) && $stable(m_c1)
                              && $stable(m_cy0) && $stable(m_cy1)));

  // R1: no result is presented in the first cycle after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    !rst_n |=> !m_valid);

endmodule

// File: tb/test_mcm_share_mult.sv
module test_mcm_share_mult;

  localparam int K     = 8;
  localparam int LANES = 2;
  localparam int OPW   = K * LANES;
  localparam int NVEC  = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic s_valid, s_ready, m_valid, m_ready;
  logic [OPW-1:0] s_a0, s_a1, s_b0, s_b1, m_c0, m_c1;
  logic [31:0] s_rnd;
  logic [LANES-1:0] m_cy0, m_cy1;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [95:0] sbq[$];

  always #4 clk = ~clk;

  mcm_share_mult i_mcm_share_mult (
    .clk(clk), .rst_n(rst_n),
    .s_valid(s_valid), .s_ready(s_ready),
    .s_a0(s_a0), .s_a1(s_a1), .s_b0(s_b0), .s_b1(s_b1), .s_rnd(s_rnd),
    .m_valid(m_valid), .m_ready(m_ready),
    .m_c0(m_c0), .m_c1(m_c1), .m_cy0(m_cy0), .m_cy1(m_cy1)
  );

  // Beat layout: {a0, a1, b0, b1, rnd}, lane 0 in the low byte of each share.
  localparam logic [95:0] VEC [NVEC] = '{
    {16'h000A, 16'h00F8, 16'h0002, 16'h0001, 32'h0000_0000},
    {16'h0000, 16'h0000, 16'h0000, 16'h0000, 32'hFFFF_FFFF},
    {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 32'h0000_0000},
    {16'hFFFF, 16'hFFFF, 16'hFFFF, 16'hFFFF, 32'hFFFF_FFFF},
    {16'h1234, 16'hABCD, 16'h5678, 16'h9ABC, 32'hDEAD_BEEF},
    {16'h8001, 16'h7FFF, 16'h00FF, 16'hFF01, 32'h0102_0304},
    {16'h0100, 16'h0001, 16'h8080, 16'h0101, 32'h8000_0080},
    {16'hC3A5, 16'h3C5A, 16'h0F0F, 16'hF0F0, 32'h5A5A_A5A5}
  };

  task automatic chk(input bit ok, input string msg);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s", msg);
    end
  endtask

  // Compare the current outputs against a queued input beat (R2, R3, R4, R5).
  task automatic check_beat(input logic [95:0] b);
    logic [OPW-1:0] a0, a1, b0, b1;
    logic [31:0] rnd;
    a0 = b[95:80]; a1 = b[79:64]; b0 = b[63:48]; b1 = b[47:32]; rnd = b[31:0];
    for (int l = 0; l < LANES; l++) begin
      logic [K-1:0] xa0, xa1, xb0, xb1, r0, r1, t00, t01, t10, t11;
      logic [K-1:0] e0, e1, prod, got_sum;
      logic [K:0] w0, w1;
      xa0 = a0[l*K +: K]; xa1 = a1[l*K +: K];
      xb0 = b0[l*K +: K]; xb1 = b1[l*K +: K];
      r0 = rnd[(2*l)*K +: K]; r1 = rnd[(2*l+1)*K +: K];
      t00 = xa0 * xb0 + r0; t01 = xa0 * xb1 + r1;
      t10 = xa1 * xb0 - r0; t11 = xa1 * xb1 - r1;
      w0 = {1'b0, t00} + {1'b0, t01};
      w1 = {1'b0, t10} + {1'b0, t11};
      e0 = w0[K-1:0]; e1 = w1[K-1:0];
      prod = (xa0 + xa1) * (xb0 + xb1);
      got_sum = m_c0[l*K +: K] + m_c1[l*K +: K];
      chk(got_sum == prod, $sformatf("R2 lane %0d recombined got %h exp %h", l, got_sum, prod));
      chk(m_c0[l*K +: K] == e0 && m_c1[l*K +: K] == e1,
          $sformatf("R3/R4/R8 lane %0d shares got %h,%h exp %h,%h",
                    l, m_c0[l*K +: K], m_c1[l*K +: K], e0, e1));
      chk(m_cy0[l] == w0[K] && m_cy1[l] == w1[K],
          $sformatf("R5 lane %0d carries got %b%b exp %b%b", l, m_cy0[l], m_cy1[l], w0[K], w1[K]));
    end
  endtask

  // One clock: inputs were set at the falling edge; record transfers, advance.
  task automatic cycle();
    #1;
    if (s_valid && s_ready) sbq.push_back({s_a0, s_a1, s_b0, s_b1, s_rnd});
    if (m_valid && m_ready) begin
      if (sbq.size() == 0) chk(1'b0, "R8 result with no beat outstanding got 1 exp 0");
      else check_beat(sbq.pop_front());
    end
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic [95:0] b);
    {s_a0, s_a1, s_b0, s_b1, s_rnd} = b;
  endtask

  function automatic logic [95:0] rand_beat();
    logic [OPW-1:0] sa, sb, a0, b0;
    sa = OPW'($urandom); sb = OPW'($urandom);
    a0 = OPW'($urandom); b0 = OPW'($urandom);
    return {a0, sa - a0, b0, sb - b0, 32'($urandom)};
  endfunction

  task automatic drain();
    s_valid = 1'b0; m_ready = 1'b1;
    for (int i = 0; i < 10; i++) cycle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++; n_chk++;
      $display("FAIL watchdog expired got running exp finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [OPW-1:0] h0, h1;
    logic [LANES-1:0] hy0, hy1;
    rst_n = 1'b0; s_valid = 1'b0; m_ready = 1'b1;
    drive('0);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(m_valid == 1'b0, $sformatf("R1 m_valid in reset got %b exp 0", m_valid));
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    chk(m_valid == 1'b0 && s_ready == 1'b1,
        $sformatf("R1 after reset valid/ready got %b%b exp 01", m_valid, s_ready));

    // Vector table, one beat at a time.
    for (int v = 0; v < NVEC; v++) begin
      drive(VEC[v]); s_valid = 1'b1;
      cycle();
      s_valid = 1'b0;
      for (int w = 0; w < 4; w++) cycle();
    end
    chk(sbq.size() == 0, $sformatf("R8 table beats outstanding got %0d exp 0", sbq.size()));

    // R6: exact latency with empty pipe.
    drive(VEC[4]); s_valid = 1'b1;
    cycle();
    s_valid = 1'b0;
    chk(m_valid == 1'b0, $sformatf("R6 one edge after accept got %b exp 0", m_valid));
    cycle();
    chk(m_valid == 1'b1, $sformatf("R6 two edges after accept got %b exp 1", m_valid));
    drain();

    // R6: back-to-back acceptance.
    s_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      drive(VEC[i]);
      #1;
      chk(s_ready == 1'b1, $sformatf("R6 streaming ready got %b exp 1", s_ready));
      @(negedge clk) ;
      sbq.push_back(VEC[i]);
      if (sbq.size() > 2) void'(sbq.pop_front());
    end
    // Re-synchronise: the stream above bypassed the scoreboard, so reset it.
    s_valid = 1'b0;
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    rst_n = 1'b1;
    sbq.delete();
    chk(m_valid == 1'b0, $sformatf("R1 reset drops in-flight beats got %b exp 0", m_valid));
    @(posedge clk); @(negedge clk);
    chk(m_valid == 1'b0, $sformatf("R1 nothing reappears after reset got %b exp 0", m_valid));

    // R7: back-pressure fills both stages, then blocks input and freezes output.
    m_ready = 1'b0; s_valid = 1'b1;
    drive(VEC[5]); cycle();
    drive(VEC[6]); cycle();
    drive(VEC[7]);
    #1;
    chk(s_ready == 1'b0, $sformatf("R7 full and stalled ready got %b exp 0", s_ready));
    chk(m_valid == 1'b1, $sformatf("R7 stalled result present got %b exp 1", m_valid));
    h0 = m_c0; h1 = m_c1; hy0 = m_cy0; hy1 = m_cy1;
    for (int i = 0; i < 4; i++) begin
      cycle();
      chk(m_valid && m_c0 == h0 && m_c1 == h1 && m_cy0 == hy0 && m_cy1 == hy1,
          $sformatf("R7 held result got %h/%h exp %h/%h", m_c0, m_c1, h0, h1));
    end
    m_ready = 1'b1;
    cycle();
    s_valid = 1'b0;
    drain();
    chk(sbq.size() == 0, $sformatf("R8 stall beats outstanding got %0d exp 0", sbq.size()));

    // Random secrets and splits, random gaps and stalls.
    for (int i = 0; i < 400; i++) begin
      if (!(s_valid && !s_ready)) begin
        s_valid = ($urandom % 4) != 0;
        drive(rand_beat());
      end
      m_ready = ($urandom % 3) != 0;
      cycle();
    end
    drain();
    chk(sbq.size() == 0, $sformatf("R8 random beats outstanding got %0d exp 0", sbq.size()));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule